// File: doc/BRIEF.md
# General-Purpose I/O Port with Edge and Level Interrupts

This block is a register-mapped port of up to 32 general-purpose pins. A CPU reaches eight word registers through a single-cycle register bus: a word index, write data and a write strobe, with read data returned combinationally for the selected word. The block drives a pad output vector and an active-high pad output-enable vector. It also takes in an asynchronous pin vector and resynchronises it through two flops per pin.

Every synchronised input is XORed with a per-pin polarity bit before anything else uses it. This adjusted value is what software reads back as the input word. A rising edge of the adjusted value latches a bit in the cause register. The level request follows the adjusted value through the level mask and does not latch. Because of this, software can catch both edges of a pin by flipping its polarity bit after each event. One registered interrupt line ORs the edge requests (cause AND edge mask) with the level requests (adjusted input AND level mask) over all pins. Any pin whose blink bit is set drives its pad output from a shared free-running square wave instead of its data-out bit.

Top module: `gpio_port`

## Requirements
- R1: After reset the pad output-enable vector is all 0, the pad output is 0, the interrupt line is 0, the output-enable register reads all ones and the other writable registers and the cause register read 0.
- R2: The writable registers sit at these word indices: 0 data out, 1 output enable, 2 blink enable, 3 input polarity, 6 edge mask (byte offset 0x18), 7 level mask (byte offset 0x1C). Each reads back the last value written. A write to index 4 (input word) has no effect on what that index reads.
- R3: The output-enable register is active-low. A 0 bit makes the pad output-enable bit 1, and a 1 bit makes it 0.
- R4: A pad output bit equals its data-out bit while its blink bit is 0. While its blink bit is 1 it follows a common square wave that changes every BLINK_HALF clock cycles.
- R5: Index 4 reads the pin vector XOR the polarity register. A pin change appears there two clock edges after it is applied, and a polarity write takes effect at the edge that stores it.
- R6: A cause bit (index 5) is set at the clock edge that follows a 0-to-1 change of the polarity-adjusted input of that pin. A 1-to-0 change sets nothing.
- R7: Writing the cause register keeps each bit written as 1 and clears each bit written as 0. Writing 1 never sets a bit. An edge arriving in the same cycle as a clearing write leaves its bit set.
- R8: The interrupt line is, one cycle later, the OR over all pins of (cause AND edge mask) and (adjusted input AND level mask). The level part does not latch, so the line drops once the level source goes away.
- R9: Setting a polarity bit while its pin is low makes a rising adjusted edge, so the cause bit is set at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 3 | Word index of the accessed register |
| reg_wdata | input | NPINS | Write data |
| reg_we | input | 1 | Write strobe, one write per asserted cycle |
| reg_rdata | output | NPINS | Read data of the word at reg_idx |
| pins_in | input | NPINS | Asynchronous pin levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad output enables, 1 drives |
| irq | output | 1 | Combined registered interrupt request |

## Verification
The assertions assume that pin levels reach the core only through the synchroniser. They also assume that a write to index 5 is the only way the cause register loses bits. The edge and clear properties therefore compare the cause register only against the internal rise vector and the write data of the previous cycle. The stimulus changes pins and bus signals just after a rising edge, holds the write strobe for exactly one cycle, and waits at least three edges after a pin change before it judges a cause bit or the interrupt line. For the same-cycle case it times a clearing write to land on the edge where a rise is detected.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_DOUT  = 3'd0,
        IDX_OEN   = 3'd1,
        IDX_BLINK = 3'd2,
        IDX_POL   = 3'd3,
        IDX_DIN   = 3'd4,
        IDX_CAUSE = 3'd5,
        IDX_EMASK = 3'd6,
        IDX_LMASK = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_async,
    output logic [NPINS-1:0] pins_sync
);
    typedef struct packed {
        logic [NPINS-1:0] meta;
        logic [NPINS-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = pins_async;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pins_sync = st_q.stable;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [NPINS-1:0]     reg_wdata,
    input  logic                 reg_we,
    output logic [NPINS-1:0]     reg_rdata,
    input  logic [NPINS-1:0]     din_adj,
    input  logic [NPINS-1:0]     cause,
    output logic                 cause_we,
    output logic [NPINS-1:0]     dout,
    output logic [NPINS-1:0]     oen,
    output logic [NPINS-1:0]     blink,
    output logic [NPINS-1:0]     pol,
    output logic [NPINS-1:0]     emask,
    output logic [NPINS-1:0]     lmask
);
    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] oen;
        logic [NPINS-1:0] blink;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] emask;
        logic [NPINS-1:0] lmask;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        cause_we = 1'b0;
        if (reg_we) begin
            case (reg_idx_e'(reg_idx))
                IDX_DOUT:  st_d.dout  = reg_wdata;
                IDX_OEN:   st_d.oen   = reg_wdata;
                IDX_BLINK: st_d.blink = reg_wdata;
                IDX_POL:   st_d.pol   = reg_wdata;
                IDX_EMASK: st_d.emask = reg_wdata;
                IDX_LMASK: st_d.lmask = reg_wdata;
                IDX_CAUSE: cause_we   = 1'b1;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.oen <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_idx_e'(reg_idx))
            IDX_DOUT:  reg_rdata = st_q.dout;
            IDX_OEN:   reg_rdata = st_q.oen;
            IDX_BLINK: reg_rdata = st_q.blink;
            IDX_POL:   reg_rdata = st_q.pol;
            IDX_DIN:   reg_rdata = din_adj;
            IDX_CAUSE: reg_rdata = cause;
            IDX_EMASK: reg_rdata = st_q.emask;
            IDX_LMASK: reg_rdata = st_q.lmask;
            default:   reg_rdata = '0;
        endcase
    end

    assign dout  = st_q.dout;
    assign oen   = st_q.oen;
    assign blink = st_q.blink;
    assign pol   = st_q.pol;
    assign emask = st_q.emask;
    assign lmask = st_q.lmask;

    // R2: a write to the input word leaves every stored register unchanged
    assert_din_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == IDX_DIN) |=> (st_q == $past(st_q)));
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_sync,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] emask,
    input  logic [NPINS-1:0] lmask,
    input  logic             cause_we,
    input  logic [NPINS-1:0] cause_wdata,
    output logic [NPINS-1:0] din_adj,
    output logic [NPINS-1:0] cause,
    output logic             irq
);
    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] cause;
        logic             irq;
    } irq_t;

    irq_t             st_d, st_q;
    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] kept;

    always_comb begin
        din_adj    = pins_sync ^ pol;
        rise       = din_adj & ~st_q.prev;
        kept       = cause_we ? (st_q.cause & cause_wdata) : st_q.cause;
        st_d       = st_q;
        st_d.prev  = din_adj;
        st_d.cause = kept | rise;
        st_d.irq   = |((st_q.cause & emask) | (din_adj & lmask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause = st_q.cause;
    assign irq   = st_q.irq;

    assert_edge_sets_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((st_q.cause & $past(rise)) == $past(rise)));

    assert_no_spurious_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.cause & ~$past(st_q.cause) & ~$past(rise)) == '0));

    assert_clear_by_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_we && rise == '0) |=> (st_q.cause == ($past(st_q.cause) & $past(cause_wdata))));

    assert_level_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((din_adj & lmask) != '0) |=> irq);

    assert_masked_edge_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cause & emask) != '0) |=> irq);
endmodule

// File: rtl/gpio_port_blink.sv
module gpio_port_blink #(
    parameter int NPINS      = 32,
    parameter int BLINK_HALF = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] dout,
    input  logic [NPINS-1:0] blink,
    output logic [NPINS-1:0] pad_out
);
    localparam int CNT_W = $clog2(BLINK_HALF + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLINK_HALF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } blink_t;

    blink_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CNT_LAST) begin
            st_d.cnt   = '0;
            st_d.phase = ~st_q.phase;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pad_out = (blink & {NPINS{st_q.phase}}) | (~blink & dout);

    assert_phase_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != CNT_LAST) |=> $stable(st_q.phase));

    assert_phase_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_LAST) |=> (st_q.phase != $past(st_q.phase)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter int BLINK_HALF = 1000000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [NPINS-1:0]     reg_wdata,
    input  logic                 reg_we,
    output logic [NPINS-1:0]     reg_rdata,
    input  logic [NPINS-1:0]     pins_in,
    output logic [NPINS-1:0]     pad_out,
    output logic [NPINS-1:0]     pad_oe,
    output logic                 irq
);
    logic [NPINS-1:0] pins_sync, din_adj, cause;
    logic [NPINS-1:0] dout, oen, blink, pol, emask, lmask;
    logic             cause_we;

    gpio_port_sync #(.NPINS(NPINS)) sync_i (
        .clk(clk), .rst_n(rst_n), .pins_async(pins_in), .pins_sync(pins_sync)
    );

    gpio_port_regs #(.NPINS(NPINS)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
        .din_adj(din_adj), .cause(cause), .cause_we(cause_we),
        .dout(dout), .oen(oen), .blink(blink), .pol(pol), .emask(emask), .lmask(lmask)
    );

    gpio_port_irq #(.NPINS(NPINS)) irq_i (
        .clk(clk), .rst_n(rst_n),
        .pins_sync(pins_sync), .pol(pol), .emask(emask), .lmask(lmask),
        .cause_we(cause_we), .cause_wdata(reg_wdata),
        .din_adj(din_adj), .cause(cause), .irq(irq)
    );

    gpio_port_blink #(.NPINS(NPINS), .BLINK_HALF(BLINK_HALF)) blink_i (
        .clk(clk), .rst_n(rst_n), .dout(dout), .blink(blink), .pad_out(pad_out)
    );

    assign pad_oe = ~oen;

    // R3: an output-enable write reaches the pads inverted one edge later
    assert_oe_active_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == IDX_OEN) |=> (pad_oe == ~$past(reg_wdata)));
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
    import gpio_port_pkg::*;

    localparam int NPINS = 32;
    localparam int HALF  = 8;

    typedef struct packed {
        logic [2:0]  idx;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{3'd0, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
        '{3'd1, 32'h1234_5678, 32'h1234_5678},
        '{3'd2, 32'h0000_00FF, 32'h0000_00FF},
        '{3'd3, 32'h8000_0001, 32'h8000_0001},
        '{3'd6, 32'hFFFF_0000, 32'hFFFF_0000},
        '{3'd7, 32'h0000_FFFF, 32'h0000_FFFF},
        '{3'd4, 32'hFFFF_FFFF, 32'h8000_0001},
        '{3'd2, 32'h0000_0000, 32'h0000_0000},
        '{3'd3, 32'h0000_0000, 32'h0000_0000},
        '{3'd6, 32'h0000_0000, 32'h0000_0000},
        '{3'd7, 32'h0000_0000, 32'h0000_0000},
        '{3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        '{3'd0, 32'h0000_0000, 32'h0000_0000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        reg_idx = '0;
    logic [NPINS-1:0]  reg_wdata = '0;
    logic              reg_we = 1'b0;
    logic [NPINS-1:0]  reg_rdata;
    logic [NPINS-1:0]  pins = '0;
    logic [NPINS-1:0]  pad_out, pad_oe;
    logic              irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port #(.NPINS(NPINS), .BLINK_HALF(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
        .pins_in(pins), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        reg_idx   = idx;
        reg_wdata = d;
        reg_we    = 1'b1;
        tick();
        reg_we    = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] idx, input logic [31:0] exp);
        reg_idx = idx;
        #1;
        check(req, reg_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int toggles;
        logic prev3;
        logic other_ok;
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd_check("R1 oen", 3'd1, 32'hFFFF_FFFF);
        rd_check("R1 dout", 3'd0, 32'h0);
        rd_check("R1 cause", 3'd5, 32'h0);

        // R2 table walk, R3 at output-enable writes
        foreach (VECS[k]) begin
            wr(VECS[k].idx, VECS[k].wd);
            rd_check("R2 readback", VECS[k].idx, VECS[k].exp);
            if (VECS[k].idx == 3'd1) check("R3 pad_oe", pad_oe, ~VECS[k].wd);
        end
        tick(4);
        wr(3'd5, 32'h0);
        rd_check("R7 clear all", 3'd5, 32'h0);

        // R4 blink
        wr(3'd0, 32'h0000_0009);
        check("R4 follow dout", pad_out, 32'h0000_0009);
        wr(3'd2, 32'h0000_0008);
        toggles = 0;
        other_ok = 1'b1;
        prev3 = pad_out[3];
        for (int c = 0; c < 4 * HALF; c++) begin
            tick();
            if (pad_out[3] != prev3) toggles++;
            prev3 = pad_out[3];
            if (pad_out[0] !== 1'b1) other_ok = 1'b0;
        end
        check("R4 blink toggles", toggles, 4);
        check("R4 non-blink pin steady", {31'h0, other_ok}, 32'h1);
        wr(3'd2, 32'h0);
        check("R4 blink off", pad_out, 32'h0000_0009);

        // R5 input path
        pins = 32'h5;
        tick();
        rd_check("R5 one edge", 3'd4, 32'h0);
        tick();
        rd_check("R5 two edges", 3'd4, 32'h5);
        wr(3'd3, 32'h3);
        rd_check("R5 polarity", 3'd4, 32'h6);
        pins = 32'h0;
        wr(3'd3, 32'h0);
        tick(4);
        wr(3'd5, 32'h0);

        // R6 rising edge latch
        pins[4] = 1'b1;
        tick(2);
        rd_check("R6 not yet", 3'd5, 32'h0);
        tick();
        rd_check("R6 rise", 3'd5, 32'h10);
        wr(3'd5, 32'h0);
        pins[4] = 1'b0;
        tick(4);
        rd_check("R6 fall ignored", 3'd5, 32'h0);

        // R9 polarity flip makes an edge
        wr(3'd3, 32'h20);
        rd_check("R9 same edge", 3'd5, 32'h0);
        tick();
        rd_check("R9 next edge", 3'd5, 32'h20);

        // R7 selective clear and edge-wins
        pins[4] = 1'b1;
        tick(3);
        rd_check("R7 setup", 3'd5, 32'h30);
        wr(3'd5, 32'hFFFF_FFEF);
        rd_check("R7 selective", 3'd5, 32'h20);
        pins[6] = 1'b1;
        tick(2);
        wr(3'd5, 32'h0);
        rd_check("R7 edge wins", 3'd5, 32'h40);

        // R8 interrupt line
        check("R8 idle", {31'h0, irq}, 32'h0);
        wr(3'd6, 32'h40);
        check("R8 edge lag", {31'h0, irq}, 32'h0);
        tick();
        check("R8 edge irq", {31'h0, irq}, 32'h1);
        wr(3'd5, 32'h0);
        tick();
        check("R8 edge cleared", {31'h0, irq}, 32'h0);
        wr(3'd6, 32'h0);
        wr(3'd7, 32'h80);
        pins[7] = 1'b1;
        tick(2);
        check("R8 level lag", {31'h0, irq}, 32'h0);
        tick();
        check("R8 level irq", {31'h0, irq}, 32'h1);
        pins[7] = 1'b0;
        tick(3);
        check("R8 level not latched", {31'h0, irq}, 32'h0);
        rd_check("R6 masked edge latched", 3'd5, 32'h80);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule